// File: doc/BRIEF.md
# Four-Requester DMA Bus Arbiter

The arbiter sits between four DMA requesters (receive and transmit for each of two serial links) and a host CPU that owns the memory bus. When any requester raises its line, the arbiter asks the CPU for the bus. Once the CPU acknowledges, it grants one requester at a time by fixed priority. After each transfer it picks the next pending requester, including any that arrived during the transfer. It gives the bus back only when nothing is left to serve or when the CPU has withdrawn its acknowledge.

A separate transfer engine performs each transfer and pulses a done strobe when it finishes. Requesters drive level requests. A requester that has more to move simply keeps its line high through the done cycle. Each requester also supplies a memory-bank field, and the arbiter presents the granted requester's field next to the grant.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While idle, a request on any channel raises busReq on the following clock edge.
- R2: No grant is issued while busAck is low. The first grant appears on the edge after busAck is sampled high with at least one request pending.
- R3: The grant goes to the lowest-index requesting channel: bit 0 receive link 1, bit 1 transmit link 1, bit 2 receive link 2, bit 3 transmit link 2.
- R4: chGrant is one-hot while a transfer is active and all-zero otherwise.
- R5: A grant does not change until xferDone is sampled high.
- R6: When xferDone is sampled with busAck high and a request pending, the next grant follows on the next edge and busReq stays high. This includes requests that arrived during the transfer.
- R7: When xferDone is sampled with no request pending, grant, busOwned and busReq all go low on the next edge.
- R8: If busAck drops during a transfer, that transfer still runs to xferDone. No further grant is then issued, and busReq drops.
- R9: grantBank equals the granted channel's field chBank[i*BANK_W +: BANK_W], and is zero when no grant is active.
- R10: In reset, busReq, busOwned, chGrant and grantBank are all zero.
- R11: If every request is withdrawn while busAck is still low, busReq drops on the next edge.
- R12: busOwned is high exactly while a grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chReq | input | NUM_CH | Level service requests, bit 0 highest priority |
| chBank | input | NUM_CH*BANK_W | Per-channel memory-bank fields |
| busAck | input | 1 | Bus acknowledge from the CPU |
| xferDone | input | 1 | Current transfer finished |
| busReq | output | 1 | Bus request to the CPU |
| busOwned | output | 1 | Arbiter is running a granted transfer |
| chGrant | output | NUM_CH | One-hot channel grant |
| grantBank | output | BANK_W | Bank field of the granted channel |

## Verification
The assertions check on every cycle that the grant stays one-hot, that it holds steady between done strobes, that it matches the winning request of the edge that loaded it, and that busOwned tracks the grant. They also check that the bus is never granted without acknowledge and is kept or released correctly at each done strobe. Only the bench scenarios can show the full sequence. These cover a burst of four requests served in priority order, a higher-priority request arriving mid-transfer and overtaking, acknowledge withdrawn mid-transfer, and a request withdrawn before acknowledge. The bank output is also shown following each grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } arbState_t;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } grantStrobe_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyReq,
  input  logic         busAck,
  input  logic         xferDone,
  input  logic         grantActive,
  output grantStrobe_t strobe,
  output logic         busReq,
  output logic         busOwned
);
  arbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (anyReq) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (busAck) begin
          if (anyReq) begin
            stateNext        = ST_XFER;
            strobe.loadGrant = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end else if (!anyReq) begin
          stateNext = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (xferDone) begin
          if (busAck && anyReq) begin
            strobe.loadGrant = 1'b1;
          end else begin
            strobe.clearGrant = 1'b1;
            stateNext         = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busReq   = (state != ST_IDLE);
  assign busOwned = (state == ST_XFER);

  // R2: nothing is granted while the CPU withholds acknowledge
  a_r2_no_grant_without_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!busOwned && !busAck) |=> !busOwned);
  // R6: the bus is kept across back-to-back requests
  a_r6_hold_bus: assert property (@(posedge clk) disable iff (!rstN)
    (busOwned && xferDone && busAck && anyReq) |=> (busOwned && busReq));
  // R7: the bus is released when nothing is pending
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    (busOwned && xferDone && !anyReq) |=> (!busReq && !busOwned));
  // R8: a lost acknowledge ends ownership after the current transfer
  a_r8_ack_lost: assert property (@(posedge clk) disable iff (!rstN)
    (busOwned && xferDone && !busAck) |=> !busOwned);
  // R11: a withdrawn request while waiting drops the bus request
  a_r11_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busOwned && !busAck && !anyReq) |=> !busReq);
  // R12: ownership tracks the datapath grant
  a_r12_owned_matches_grant: assert property (@(posedge clk) disable iff (!rstN)
    busOwned == grantActive);
endmodule

// File: rtl/dma_arb_dpath.sv
module dma_arb_dpath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BANK_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH-1:0]          chReq,
  input  logic [NUM_CH*BANK_W-1:0]   chBank,
  input  logic                       xferDone,
  input  grantStrobe_t               strobe,
  output logic                       anyReq,
  output logic                       grantActive,
  output logic [NUM_CH-1:0]          chGrant,
  output logic [BANK_W-1:0]          grantBank
);
  logic [NUM_CH-1:0] winner;
  logic [BANK_W-1:0] bankMasked [NUM_CH];

  assign anyReq = |chReq;

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    winner = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chReq[i]) begin
        winner    = '0;
        winner[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  chGrant <= '0;
    else if (strobe.clearGrant) chGrant <= '0;
    else if (strobe.loadGrant)  chGrant <= winner;
  end

  assign grantActive = |chGrant;

  for (genvar g = 0; g < NUM_CH; g++) begin : gBank
    assign bankMasked[g] = chGrant[g] ? chBank[g*BANK_W +: BANK_W] : '0;
  end

  always_comb begin
    grantBank = '0;
    for (int i = 0; i < NUM_CH; i++) grantBank |= bankMasked[i];
  end

  // R4: at most one grant at a time
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chGrant));
  // R5: grant holds until the transfer engine reports done
  a_r5_grant_stable: assert property (@(posedge clk) disable iff (!rstN)
    (grantActive && !xferDone) |=> $stable(chGrant));
  // R3: a newly loaded grant belongs to the lowest requesting channel
  a_r3_priority: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadGrant |=> (((chGrant & $past(chReq)) != '0) &&
                          ((((chGrant - 1'b1) & $past(chReq))) == '0)));
  // R9: no bank field leaks without a grant
  a_r9_bank_idle: assert property (@(posedge clk) disable iff (!rstN)
    !grantActive |-> (grantBank == '0));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chReq,
  input  logic [NUM_CH*BANK_W-1:0] chBank,
  input  logic                     busAck,
  input  logic                     xferDone,
  output logic                     busReq,
  output logic                     busOwned,
  output logic [NUM_CH-1:0]        chGrant,
  output logic [BANK_W-1:0]        grantBank
);
  grantStrobe_t strobe;
  logic anyReq;
  logic grantActive;

  dma_arb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .busAck(busAck),
    .xferDone(xferDone), .grantActive(grantActive), .strobe(strobe),
    .busReq(busReq), .busOwned(busOwned)
  );

  dma_arb_dpath #(.NUM_CH(NUM_CH), .BANK_W(BANK_W)) uDpath (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chBank(chBank),
    .xferDone(xferDone), .strobe(strobe), .anyReq(anyReq),
    .grantActive(grantActive), .chGrant(chGrant), .grantBank(grantBank)
  );
endmodule

// File: tb/sim_dma_bus_arbiter.sv
module sim_dma_bus_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]  chReq = '0;
  logic [15:0] chBank = 16'h9C5A;
  logic busAck = 1'b0;
  logic xferDone = 1'b0;
  logic busReq, busOwned;
  logic [3:0] chGrant;
  logic [3:0] grantBank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference: 0 idle, 1 asking, 2 transferring
  int mState = 0;
  int mGrant = -1;

  always #4 clk = ~clk;

  dma_bus_arbiter u0 (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chBank(chBank),
    .busAck(busAck), .xferDone(xferDone), .busReq(busReq),
    .busOwned(busOwned), .chGrant(chGrant), .grantBank(grantBank)
  );

  function automatic int lowestReq(input logic [3:0] r);
    for (int i = 3; i >= 0; i--) if (r[i]) lowestReq = i;
    if (r == 0) lowestReq = -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mGrant = -1;
    end else begin
      cycles++;
      if (mState == 0) begin
        if (chReq != 0) mState = 1;
      end else if (mState == 1) begin
        if (busAck) begin
          if (chReq != 0) begin mState = 2; mGrant = lowestReq(chReq); end
          else mState = 0;
        end else if (chReq == 0) mState = 0;
      end else if (xferDone) begin
        if (busAck && chReq != 0) mGrant = lowestReq(chReq);
        else begin mState = 0; mGrant = -1; end
      end
    end
  end

  task automatic compareAll();
    logic expReq, expOwn;
    logic [3:0] expGnt, expBank;
    expReq  = (mState != 0);
    expOwn  = (mState == 2);
    expGnt  = (mGrant >= 0) ? (4'b1 << mGrant) : 4'b0;
    expBank = (mGrant >= 0) ? chBank[mGrant*4 +: 4] : 4'b0;
    checks += 4;
    if (busReq !== expReq) begin
      errors++; $display("FAIL R1/R6/R7/R11 busReq got %0b exp %0b t=%0t", busReq, expReq, $time);
    end
    if (busOwned !== expOwn) begin
      errors++; $display("FAIL R2/R8/R12 busOwned got %0b exp %0b t=%0t", busOwned, expOwn, $time);
    end
    if (chGrant !== expGnt) begin
      errors++; $display("FAIL R3/R4/R5 chGrant got %b exp %b t=%0t", chGrant, expGnt, $time);
    end
    if (grantBank !== expBank) begin
      errors++; $display("FAIL R9 grantBank got %h exp %h t=%0t", grantBank, expBank, $time);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic a, input logic d);
    @(negedge clk);
    compareAll();
    chReq = r; busAck = a; xferDone = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll();                       // R10: reset state
    rstN = 1'b1;
    // R1 R2 R7: single request on channel 2, ack late, release after done
    step(4'b0100, 0, 0);
    step(4'b0100, 0, 0);
    step(4'b0100, 0, 0);
    step(4'b0100, 1, 0);
    step(4'b0100, 1, 0);
    step(4'b0000, 1, 1);
    step(4'b0000, 1, 0);
    step(4'b0000, 0, 0);
    // R3 R5 R6: all four at once, served 0,1,2,3
    step(4'b1111, 0, 0);
    step(4'b1111, 1, 0);
    step(4'b1111, 1, 0);
    step(4'b1110, 1, 1);
    step(4'b1110, 1, 0);
    step(4'b1100, 1, 1);
    step(4'b1100, 1, 0);
    chBank = 16'h37E1;                  // R9: bank follows live field
    step(4'b1000, 1, 1);
    step(4'b1000, 1, 0);
    step(4'b0000, 1, 1);
    step(4'b0000, 1, 0);
    // R6 R3: channel 0 arrives during channel 3 transfer and overtakes
    step(4'b1000, 1, 0);
    step(4'b1000, 1, 0);
    step(4'b1000, 1, 0);
    step(4'b1001, 1, 0);
    step(4'b1001, 1, 1);
    step(4'b1000, 1, 0);
    step(4'b1000, 1, 1);
    step(4'b0000, 1, 0);
    step(4'b0000, 1, 1);
    step(4'b0000, 0, 0);
    // R8: ack lost mid-transfer, transfer completes, no new grant
    step(4'b0011, 1, 0);
    step(4'b0011, 1, 0);
    step(4'b0011, 0, 0);
    step(4'b0011, 0, 0);
    step(4'b0010, 0, 1);
    step(4'b0010, 0, 0);
    step(4'b0010, 1, 0);
    step(4'b0010, 1, 0);
    step(4'b0000, 1, 1);
    step(4'b0000, 0, 0);
    // R11: request withdrawn before ack
    step(4'b0001, 0, 0);
    step(4'b0001, 0, 0);
    step(4'b0000, 0, 0);
    step(4'b0000, 0, 0);
    // R10: reset mid-transfer clears everything
    step(4'b0100, 1, 0);
    step(4'b0100, 1, 0);
    step(4'b0100, 1, 0);
    rstN = 1'b0;
    step(4'b0000, 0, 0);
    step(4'b0000, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d exp below 5000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule